// File: doc/BRIEF.md
# Dual-Width Arithmetic Logic Unit with Bit Modify

This block is the purely combinational arithmetic logic unit of a small 16-bit register-based processor. Each operand is presented twice: once as an 8-bit byte and once as a 16-bit word. The unit computes both a byte result and a word result in parallel, on separate buses. A width select input then chooses which of the two results drives the condition flags.

It provides the following operations:
- add and subtract;
- an unsigned 8x8 multiply;
- AND, OR and XOR;
- setting or clearing one bit of the destination byte;
- a pass-through used for register-to-register moves.

The condition byte holds negative, zero, overflow and carry flags. Its other bits pass through untouched. Operand selection, register storage and instruction decode sit outside this block.

Top module: `dual_alu`

## Requirements
- R1: Pass-through (opSel 0) drives srcByte on byteOut and srcWord on wordOut. N and Z follow the selected-width result, V is cleared and C is kept from ccrIn.
- R2: Add (opSel 1) drives (dstByte+srcByte) mod 256 on byteOut and (dstWord+srcWord) mod 65536 on wordOut, both in the same evaluation.
- R3: For add, C is the carry out of the selected width. V is set when both operands have the same sign and the result sign differs from it. N is the result MSB and Z is set for a zero result.
- R4: Subtract (opSel 2) drives dst minus src on both buses. C is set when src is greater than dst as unsigned values (borrow). V is set when the operand signs differ and the result sign differs from the dst sign.
- R5: AND, OR and XOR (opSel 3, 4, 5) combine dst and src on both buses. N and Z come from the result, V is cleared and C is kept from ccrIn.
- R6: Multiply (opSel 6) drives the unsigned product dstByte*srcByte on wordOut and its low byte on byteOut. ccrOut equals ccrIn.
- R7: Bit set (opSel 7) and bit clear (opSel 8) force bit srcByte[2:0] of dstByte to 1 or 0 and drive the result on byteOut. wordOut carries dstWord[15:8] above that byte. ccrOut equals ccrIn.
- R8: With wordOp=1 the flags are taken from the word result; with wordOp=0 they are taken from the byte result.
- R9: The condition byte layout is bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. ccrOut[7:4] always equals ccrIn[7:4].
- R10: Unused codes (opSel 9 to 15) drive zero on both result buses and leave ccrOut equal to ccrIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcByte | input | 8 | Source operand, byte form; low 3 bits give the bit index for bit ops |
| dstByte | input | 8 | Destination operand, byte form |
| srcWord | input | 16 | Source operand, word form |
| dstWord | input | 16 | Destination operand, word form |
| opSel | input | 4 | Operation code |
| wordOp | input | 1 | 1 selects the word result for flag generation |
| ccrIn | input | 8 | Current condition byte |
| byteOut | output | 8 | Byte result bus |
| wordOut | output | 16 | Word result bus |
| ccrOut | output | 8 | Updated condition byte |

## Verification
The assertions check a set of invariants on every evaluation:
- the upper condition bits are preserved;
- multiply, bit-modify and unused codes leave the flags untouched;
- a bit op changes at most the one indexed bit;
- logic and pass-through clear V and keep C;
- Z agrees with the selected result.

The scenarios alone show that the arithmetic values are correct: carry and borrow at the width boundaries, signed overflow in both directions, and the full 0xFF*0xFF product. They also show that the width select picks the flags from the correct bus when the byte and word results disagree.

// File: rtl/dual_alu_pkg.sv
package dual_alu_pkg;
  localparam int CcrW  = 8;
  localparam int FlagC = 0;
  localparam int FlagV = 1;
  localparam int FlagZ = 2;
  localparam int FlagN = 3;

  localparam logic [3:0] OpPass = 4'd0;
  localparam logic [3:0] OpAdd  = 4'd1;
  localparam logic [3:0] OpSub  = 4'd2;
  localparam logic [3:0] OpAnd  = 4'd3;
  localparam logic [3:0] OpOr   = 4'd4;
  localparam logic [3:0] OpXor  = 4'd5;
  localparam logic [3:0] OpMul  = 4'd6;
  localparam logic [3:0] OpBset = 4'd7;
  localparam logic [3:0] OpBclr = 4'd8;

  typedef struct packed {
    logic selPass;
    logic selAdd;
    logic selSub;
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selMul;
    logic selSet;
    logic selClr;
    logic updArith;
    logic updLogic;
  } aluStrobe_t;
endpackage

// File: rtl/dual_alu_ctrl.sv
module dual_alu_ctrl
  import dual_alu_pkg::*;
(
  input  logic [3:0]  opSel,
  output aluStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    case (opSel)
      OpPass: begin strobe.selPass = 1'b1; strobe.updLogic = 1'b1; end
      OpAdd:  begin strobe.selAdd  = 1'b1; strobe.updArith = 1'b1; end
      OpSub:  begin strobe.selSub  = 1'b1; strobe.updArith = 1'b1; end
      OpAnd:  begin strobe.selAnd  = 1'b1; strobe.updLogic = 1'b1; end
      OpOr:   begin strobe.selOr   = 1'b1; strobe.updLogic = 1'b1; end
      OpXor:  begin strobe.selXor  = 1'b1; strobe.updLogic = 1'b1; end
      OpMul:  strobe.selMul = 1'b1;
      OpBset: strobe.selSet = 1'b1;
      OpBclr: strobe.selClr = 1'b1;
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/dual_alu_addsub.sv
module dual_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] bEff;
  logic [W:0]   full;

  // subtraction as a + ~b + 1; the carry is inverted to give a borrow
  assign bEff  = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, bEff} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];
  assign carry = full[W] ^ sub;
  assign ovf   = (a[W-1] == bEff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/dual_alu_dpath.sv
module dual_alu_dpath
  import dual_alu_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  aluStrobe_t          strobe,
  input  logic [ByteW-1:0]    srcByte,
  input  logic [ByteW-1:0]    dstByte,
  input  logic [2*ByteW-1:0]  srcWord,
  input  logic [2*ByteW-1:0]  dstWord,
  input  logic                wordOp,
  input  logic [CcrW-1:0]     ccrIn,
  output logic [ByteW-1:0]    byteOut,
  output logic [2*ByteW-1:0]  wordOut,
  output logic [CcrW-1:0]     ccrOut
);
  localparam int WordW = 2 * ByteW;
  localparam int IdxW  = $clog2(ByteW);

  logic [ByteW-1:0] bSum;
  logic             bCarry, bOvf;
  logic [WordW-1:0] wSum;
  logic             wCarry, wOvf;
  logic [ByteW-1:0] bitMask, bitRes;
  logic [WordW-1:0] product;
  logic             selNeg, selZero, selCarry, selOvf;

  dual_alu_addsub #(.W(ByteW)) byteAdder (
    .a(dstByte), .b(srcByte), .sub(strobe.selSub),
    .sum(bSum), .carry(bCarry), .ovf(bOvf)
  );

  dual_alu_addsub #(.W(WordW)) wordAdder (
    .a(dstWord), .b(srcWord), .sub(strobe.selSub),
    .sum(wSum), .carry(wCarry), .ovf(wOvf)
  );

  assign bitMask = ByteW'(1) << srcByte[IdxW-1:0];
  assign bitRes  = strobe.selSet ? (dstByte | bitMask) : (dstByte & ~bitMask);
  assign product = WordW'(dstByte) * WordW'(srcByte);

  always_comb begin
    byteOut = '0;
    wordOut = '0;
    if (strobe.selPass) begin
      byteOut = srcByte;
      wordOut = srcWord;
    end else if (strobe.selAdd || strobe.selSub) begin
      byteOut = bSum;
      wordOut = wSum;
    end else if (strobe.selAnd) begin
      byteOut = dstByte & srcByte;
      wordOut = dstWord & srcWord;
    end else if (strobe.selOr) begin
      byteOut = dstByte | srcByte;
      wordOut = dstWord | srcWord;
    end else if (strobe.selXor) begin
      byteOut = dstByte ^ srcByte;
      wordOut = dstWord ^ srcWord;
    end else if (strobe.selMul) begin
      byteOut = product[ByteW-1:0];
      wordOut = product;
    end else if (strobe.selSet || strobe.selClr) begin
      byteOut = bitRes;
      wordOut = {dstWord[WordW-1:ByteW], bitRes};
    end
  end

  assign selNeg   = wordOp ? wordOut[WordW-1] : byteOut[ByteW-1];
  assign selZero  = wordOp ? (wordOut == '0) : (byteOut == '0);
  assign selCarry = wordOp ? wCarry : bCarry;
  assign selOvf   = wordOp ? wOvf : bOvf;

  always_comb begin
    ccrOut = ccrIn;
    if (strobe.updArith) begin
      ccrOut[FlagN] = selNeg;
      ccrOut[FlagZ] = selZero;
      ccrOut[FlagV] = selOvf;
      ccrOut[FlagC] = selCarry;
    end else if (strobe.updLogic) begin
      ccrOut[FlagN] = selNeg;
      ccrOut[FlagZ] = selZero;
      ccrOut[FlagV] = 1'b0;
    end
  end
endmodule

// File: rtl/dual_alu.sv
module dual_alu
  import dual_alu_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic [ByteW-1:0]   srcByte,
  input  logic [ByteW-1:0]   dstByte,
  input  logic [2*ByteW-1:0] srcWord,
  input  logic [2*ByteW-1:0] dstWord,
  input  logic [3:0]         opSel,
  input  logic               wordOp,
  input  logic [7:0]         ccrIn,
  output logic [ByteW-1:0]   byteOut,
  output logic [2*ByteW-1:0] wordOut,
  output logic [7:0]         ccrOut
);
  aluStrobe_t strobe;

  dual_alu_ctrl ctrl (
    .opSel(opSel),
    .strobe(strobe)
  );

  dual_alu_dpath #(.ByteW(ByteW)) dpath (
    .strobe(strobe), .srcByte(srcByte), .dstByte(dstByte),
    .srcWord(srcWord), .dstWord(dstWord), .wordOp(wordOp),
    .ccrIn(ccrIn), .byteOut(byteOut), .wordOut(wordOut), .ccrOut(ccrOut)
  );
endmodule

// File: rtl/dual_alu_chk.sv
module dual_alu_chk #(
  parameter int ByteW = 8
) (
  input logic [ByteW-1:0]   srcByte,
  input logic [ByteW-1:0]   dstByte,
  input logic [2*ByteW-1:0] srcWord,
  input logic [2*ByteW-1:0] dstWord,
  input logic [3:0]         opSel,
  input logic               wordOp,
  input logic [7:0]         ccrIn,
  input logic [ByteW-1:0]   byteOut,
  input logic [2*ByteW-1:0] wordOut,
  input logic [7:0]         ccrOut
);
  localparam int IdxW = $clog2(ByteW);

  logic flagsFrozen, logicLike, flagged, resZero;
  assign flagsFrozen = (opSel >= 4'd6);
  assign logicLike   = (opSel == 4'd0) || (opSel == 4'd3) || (opSel == 4'd4) || (opSel == 4'd5);
  assign flagged     = (opSel <= 4'd5);
  assign resZero     = wordOp ? (wordOut == '0) : (byteOut == '0);

  always_comb begin
    AST_UPPER_KEPT: assert (ccrOut[7:4] == ccrIn[7:4]) else $error("upper ccr bits changed"); // R9
    AST_FROZEN_FLAGS: assert (!flagsFrozen || ccrOut == ccrIn) else $error("flags altered"); // R6
    AST_BITOP_ONE: assert (!(opSel == 4'd7 || opSel == 4'd8) ||
      ($countones(byteOut ^ dstByte) <= 1 &&
       byteOut[srcByte[IdxW-1:0]] == (opSel == 4'd7))) else $error("bit op wrong"); // R7
    AST_LOGIC_VC: assert (!logicLike || (!ccrOut[1] && ccrOut[0] == ccrIn[0])) else $error("logic V/C"); // R5
    AST_ZERO_FLAG: assert (!flagged || ccrOut[2] == resZero) else $error("Z mismatch"); // R8
    AST_PASS_COPY: assert (opSel != 4'd0 || (byteOut == srcByte && wordOut == srcWord)) else $error("pass"); // R1
    AST_UNUSED_ZERO: assert (opSel < 4'd9 || (byteOut == '0 && wordOut == '0)) else $error("unused"); // R10
  end
endmodule

bind dual_alu dual_alu_chk #(.ByteW(ByteW)) chk (.*);

// File: tb/dual_alu_test.sv
module dual_alu_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  srcByte, dstByte, ccrIn, byteOut, ccrOut;
  logic [15:0] srcWord, dstWord, wordOut;
  logic [3:0]  opSel;
  logic        wordOp;

  dual_alu uut (
    .srcByte(srcByte), .dstByte(dstByte), .srcWord(srcWord), .dstWord(dstWord),
    .opSel(opSel), .wordOp(wordOp), .ccrIn(ccrIn),
    .byteOut(byteOut), .wordOut(wordOut), .ccrOut(ccrOut)
  );

  typedef struct {
    logic [7:0]  b;
    logic [15:0] w;
    logic [7:0]  c;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic drive(input logic [3:0] op, input logic wop,
                       input logic [7:0] s8, input logic [7:0] d8,
                       input logic [15:0] s16, input logic [15:0] d16,
                       input logic [7:0] cc, input string tag);
    exp_t e;
    int r8, r16, rr, w, d, s, sgn;
    @(posedge clk);
    opSel = op; wordOp = wop; srcByte = s8; dstByte = d8;
    srcWord = s16; dstWord = d16; ccrIn = cc;
    r8 = 0; r16 = 0;
    case (op)
      4'd0: begin r8 = s8; r16 = s16; end
      4'd1: begin r8 = (d8 + s8) % 256; r16 = (d16 + s16) % 65536; end
      4'd2: begin r8 = (d8 - s8 + 256) % 256; r16 = (d16 - s16 + 65536) % 65536; end
      4'd3: begin r8 = d8 & s8; r16 = d16 & s16; end
      4'd4: begin r8 = d8 | s8; r16 = d16 | s16; end
      4'd5: begin r8 = d8 ^ s8; r16 = d16 ^ s16; end
      4'd6: begin r16 = d8 * s8; r8 = r16 % 256; end
      4'd7: begin r8 = d8 | (1 << s8[2:0]); r16 = (d16 & 16'hFF00) | r8; end
      4'd8: begin r8 = d8 & ~(1 << s8[2:0]) & 255; r16 = (d16 & 16'hFF00) | r8; end
      default: begin r8 = 0; r16 = 0; end
    endcase
    e.b = r8[7:0]; e.w = r16[15:0]; e.c = cc; e.tag = tag;
    w   = wop ? 16 : 8;
    sgn = 1 << (w - 1);
    d   = wop ? d16 : d8;
    s   = wop ? s16 : s8;
    rr  = wop ? r16 : r8;
    if (op <= 4'd5) begin
      e.c[3] = (rr & sgn) != 0;
      e.c[2] = (rr == 0);
      if (op == 4'd1) begin
        e.c[0] = (d + s) >= (1 << w);
        e.c[1] = (((d ^ s) & sgn) == 0) && (((rr ^ d) & sgn) != 0);
      end else if (op == 4'd2) begin
        e.c[0] = s > d;
        e.c[1] = (((d ^ s) & sgn) != 0) && (((rr ^ d) & sgn) != 0);
      end else begin
        e.c[1] = 1'b0;
      end
    end
    expQ.push_back(e);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      if (byteOut !== e.b || wordOut !== e.w || ccrOut !== e.c) begin
        bad++;
        $display("FAIL %s: got b=%h w=%h c=%h expected b=%h w=%h c=%h",
                 e.tag, byteOut, wordOut, ccrOut, e.b, e.w, e.c);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    opSel = 0; wordOp = 0; srcByte = 0; dstByte = 0; srcWord = 0; dstWord = 0; ccrIn = 0;
    // zero-input state, byte pass
    drive(4'd0, 0, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h00, "R1 zero pass");
    drive(4'd0, 1, 8'h12, 8'h55, 16'h8001, 16'h1111, 8'h03, "R1 pass word N, C kept");
    drive(4'd1, 0, 8'h22, 8'h11, 16'h1234, 16'h1111, 8'h00, "R2 add plain");
    drive(4'd1, 0, 8'h01, 8'h7F, 16'h0001, 16'h007F, 8'h00, "R3 add byte V");
    drive(4'd1, 1, 8'h01, 8'hFF, 16'h0001, 16'hFFFF, 8'h00, "R3 add word C Z");
    drive(4'd1, 1, 8'h80, 8'h80, 16'h8000, 16'h8000, 8'h00, "R3 add word neg overflow");
    drive(4'd2, 0, 8'h01, 8'h00, 16'h0001, 16'h0000, 8'h00, "R4 sub borrow");
    drive(4'd2, 0, 8'h01, 8'h80, 16'h0001, 16'h0080, 8'h00, "R4 sub V");
    drive(4'd2, 1, 8'h34, 8'h12, 16'h1234, 16'h1234, 8'h0F, "R4 sub word zero");
    drive(4'd3, 0, 8'hF0, 8'h0F, 16'hFF00, 16'h0FF0, 8'h03, "R5 and zero C kept");
    drive(4'd4, 1, 8'h80, 8'h01, 16'h8000, 16'h0001, 8'h02, "R5 or word");
    drive(4'd5, 0, 8'hFF, 8'h0F, 16'hAAAA, 16'h5555, 8'h01, "R5 xor");
    drive(4'd6, 0, 8'hFF, 8'hFF, 16'h0000, 16'h0000, 8'h05, "R6 mul max");
    drive(4'd6, 1, 8'h00, 8'h9C, 16'h1234, 16'h4321, 8'h0A, "R6 mul zero");
    drive(4'd7, 0, 8'h07, 8'h00, 16'h0000, 16'hAB00, 8'h0C, "R7 set bit 7");
    drive(4'd7, 0, 8'h02, 8'h04, 16'h0000, 16'h1204, 8'h00, "R7 set already set");
    drive(4'd8, 0, 8'hF8, 8'hFF, 16'h0000, 16'hCDFF, 8'h0F, "R7 clear bit 0");
    drive(4'd1, 0, 8'h01, 8'hFF, 16'h0001, 16'h00FF, 8'h00, "R8 byte flags carry");
    drive(4'd1, 1, 8'h01, 8'hFF, 16'h0001, 16'h00FF, 8'h00, "R8 word flags no carry");
    drive(4'd2, 1, 8'h05, 8'h03, 16'h0001, 16'h0100, 8'hA0, "R9 upper bits kept");
    drive(4'd12, 1, 8'h11, 8'h22, 16'h3333, 16'h4444, 8'h5A, "R10 unused code");
    drive(4'd15, 0, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 8'hC3, "R10 unused top code");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule